// File: doc/BRIEF.md
# Serial Configuration Word Receiver

This block takes configuration words from a single serial data line and loads them into a small bank of setting registers. The line is clocked by a word clock, and each bit is sampled on that clock's falling edge. A word begins with a low start bit. Fifteen more bits follow, most significant first. The last three of them name the destination register and the twelve before them are the data. A word is written only after the line has stayed high for a run of at least sixteen stop bits. If a low arrives before the run is complete, the pending word is dropped and that low is taken as the start of a new word.

The register contents are decoded into parallel setting outputs: receive and transmit gains, input selection, oversampling mode, loopback mode, two signed filter-tuning codes, tuning-DAC code and enable, general-purpose levels, power-down bits and a test-settings word. Writes to the test-settings register take effect only while the test input is high. Writes to unassigned identifiers are discarded.

The frame engine has three named states. IDLE waits for a start bit. SHIFT collects the fifteen bits that follow the start bit. STOP counts high stop bits. The transitions are START_SEEN (IDLE to SHIFT on a low bit), FRAME_FULL (SHIFT to STOP after the fifteenth bit), COMMIT (STOP to IDLE on the sixteenth consecutive high, which writes the word) and RESTART (STOP to SHIFT on a low bit, which drops the pending word).

Top module: `serial_cfg_rx`

## Requirements
- R1: The serial line is sampled only on the falling edge of `wclk`. A level that is present only around the rising edge has no effect.
- R2: A word is 16 bits sent most significant bit first. Bit 15 is the start bit and is 0, bits 14..3 are the 12 data bits, and bits 2..0 are the register identifier.
- R3: A committed word replaces exactly the register its identifier names: 0 gain, 1 path, 2 tuning, 3 power-down, 4 test. All other registers keep their values.
- R4: A word is committed on the falling edge that samples the 16th consecutive high stop bit. It is not committed after only 15.
- R5: A write to identifier 4 (test) is ignored while `test_mode` is 0 and is accepted while `test_mode` is 1.
- R6: While the engine is idle, high bits start nothing, however many there are. The next low bit is taken as a start bit.
- R7: A low bit that arrives while fewer than 16 stop bits have been counted discards the pending word, and that low bit becomes the start bit of a new word.
- R8: Words with identifiers 5, 6 or 7 change no register.
- R9: While `rst_n` is low the registers hold their defaults. The defaults are gain = 0x600 (input select 3, both gains at minimum), path = 0 (oversampling 4, normal mode, filter codes 0), tuning = 0 (DAC disabled), power-down = 0 and test = 0.
- R10: Field layout. Gain register: `rx_gain` [4:0], `tx_gain` [8:5], `rx_in_sel` [10:9], `ext_gain_sel` [11]. Path register: `osr_half` [0], `loop_mode` [2:1], `vco_filt` [3], `lpf_lo_code` [6:4], `lpf_hi_code` [9:7], `filt_force` [11:10]. The two filter codes are signed two's complement, from -4 (100) to +3 (011). Tuning register: `vdac_code` [7:0], `vdac_en` [8], `gp_out` [11:9]. `pwr_down` and `test_cfg` are the full power-down and test registers.
- R11: The default values are present at the outputs no later than 4 `wclk` periods after `rst_n` is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Word clock; the line is sampled on its falling edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sdi | input | 1 | Serial configuration line, high when idle |
| test_mode | input | 1 | Enables writes to the test register when high |
| rx_gain | output | 5 | Receive gain code in 1 dB steps |
| tx_gain | output | 4 | Transmit gain code, 0 is minimum |
| rx_in_sel | output | 2 | Receive input selection |
| ext_gain_sel | output | 1 | External gain control level |
| osr_half | output | 1 | 1 selects oversampling 2, 0 selects 4 |
| loop_mode | output | 2 | Loopback mode, 0 is normal |
| vco_filt | output | 1 | Tuning output filter select |
| lpf_lo_code | output | 3 | Signed tuning code of the low-band filter |
| lpf_hi_code | output | 3 | Signed tuning code of the high-band filter |
| filt_force | output | 2 | Filter routing override |
| vdac_code | output | 8 | Tuning DAC value |
| vdac_en | output | 1 | Tuning DAC enable |
| gp_out | output | 3 | General-purpose output levels |
| pwr_down | output | 12 | Per-block power-down bits |
| test_cfg | output | 12 | Test settings word |

## Verification
The bench targets the edges of the stop-bit rule. It checks that nothing is written after 15 highs and that the word is written on the 16th. A counter off by one would commit early, or would need a 17th bit. The bench sends a word whose stop run is cut short by the next start bit. A design that failed to drop the pending word, or that lost the interrupting low bit, would write the wrong data or miss the next word. The bench also holds each bit at its wrong value around the rising edge, which catches a receiver that samples on the wrong clock edge. Finally, it checks test-register gating in both `test_mode` levels and writes to every unassigned identifier, where any leak would disturb a register.

// File: rtl/cfg_rx_pkg.sv
`timescale 1ns/1ps
package cfg_rx_pkg;
    localparam int FRAME_W  = 16;
    localparam int ID_W     = 3;
    localparam int DATA_W   = FRAME_W - 1 - ID_W;
    localparam int STOP_MIN = 16;
    localparam int REG_N    = 5;

    localparam int ID_GAIN = 0;
    localparam int ID_PATH = 1;
    localparam int ID_TUNE = 2;
    localparam int ID_PWR  = 3;
    localparam int ID_TEST = 4;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_STOP  = 2'd2
    } rx_state_t;

    function automatic logic [DATA_W-1:0] reg_default(input int idx);
        logic [DATA_W-1:0] v;
        v = '0;
        if (idx == ID_GAIN) v[10:9] = 2'b11;   // input select at max attenuation
        return v;
    endfunction
endpackage

// File: rtl/cfg_frame_rx.sv
`timescale 1ns/1ps
module cfg_frame_rx
    import cfg_rx_pkg::*;
#(
    parameter int FW    = FRAME_W,
    parameter int IW    = ID_W,
    parameter int SMIN  = STOP_MIN
) (
    input  logic              wclk,
    input  logic              rst_n,
    input  logic              sdi,
    output logic              wr_stb,
    output logic [FW-IW-2:0]  wr_data,
    output logic [IW-1:0]     wr_id
);
    localparam int SH_W  = FW - 1;
    localparam int MAXC  = (SH_W > SMIN) ? SH_W : SMIN;
    localparam int CNT_W = $clog2(MAXC + 1);

    rx_state_t        st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [SH_W-1:0]  sh_q;
    logic             last_bit, stop_done;

    assign last_bit  = (cnt_q == CNT_W'(SH_W - 1));
    assign stop_done = (cnt_q == CNT_W'(SMIN - 1));

    // state register
    always_ff @(negedge wclk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // next state and outputs
    always_comb begin
        st_d   = st_q;
        cnt_d  = cnt_q;
        wr_stb = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (!sdi) begin                    // START_SEEN
                    st_d  = ST_SHIFT;
                    cnt_d = '0;
                end
            end
            ST_SHIFT: begin
                if (last_bit) begin                // FRAME_FULL
                    st_d  = ST_STOP;
                    cnt_d = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_STOP: begin
                if (!sdi) begin                    // RESTART
                    st_d  = ST_SHIFT;
                    cnt_d = '0;
                end else if (stop_done) begin      // COMMIT
                    st_d   = ST_IDLE;
                    cnt_d  = '0;
                    wr_stb = 1'b1;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: begin
                st_d  = ST_IDLE;
                cnt_d = '0;
            end
        endcase
    end

    always_ff @(negedge wclk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            sh_q  <= '0;
        end else begin
            cnt_q <= cnt_d;
            if (st_q == ST_SHIFT) sh_q <= {sh_q[SH_W-2:0], sdi};
        end
    end

    assign wr_data = sh_q[SH_W-1:IW];
    assign wr_id   = sh_q[IW-1:0];

    p_idle_hold_r6: assert property (@(negedge wclk) disable iff (!rst_n)
        (st_q == ST_IDLE && sdi) |=> (st_q == ST_IDLE));

    p_restart_r7: assert property (@(negedge wclk) disable iff (!rst_n)
        (st_q == ST_STOP && !sdi) |=> (st_q == ST_SHIFT && cnt_q == '0));

    p_commit_idle_r4: assert property (@(negedge wclk) disable iff (!rst_n)
        wr_stb |=> (st_q == ST_IDLE));

    p_start_low_r6: assert property (@(negedge wclk) disable iff (!rst_n)
        (st_q == ST_IDLE && !sdi) |=> (st_q == ST_SHIFT));
endmodule

// File: rtl/cfg_reg_bank.sv
`timescale 1ns/1ps
module cfg_reg_bank
    import cfg_rx_pkg::*;
#(
    parameter int RN   = REG_N,
    parameter int DW   = DATA_W,
    parameter int IW   = ID_W,
    parameter int TID  = ID_TEST
) (
    input  logic             wclk,
    input  logic             rst_n,
    input  logic             test_mode,
    input  logic             wr_stb,
    input  logic [DW-1:0]    wr_data,
    input  logic [IW-1:0]    wr_id,
    output logic [RN*DW-1:0] regs_flat
);
    logic [RN-1:0] we;

    for (genvar i = 0; i < RN; i++) begin : g_reg
        logic [DW-1:0] r_q;
        if (i == TID) begin : g_gated
            assign we[i] = wr_stb && (wr_id == IW'(i)) && test_mode;
        end else begin : g_plain
            assign we[i] = wr_stb && (wr_id == IW'(i));
        end
        always_ff @(negedge wclk or negedge rst_n) begin
            if (!rst_n)     r_q <= reg_default(i);
            else if (we[i]) r_q <= wr_data;
        end
        assign regs_flat[i*DW +: DW] = r_q;
    end

    p_onehot_we_r3: assert property (@(negedge wclk) disable iff (!rst_n)
        $onehot0(we));

    p_reserved_drop_r8: assert property (@(negedge wclk) disable iff (!rst_n)
        (wr_stb && wr_id >= IW'(RN)) |=> $stable(regs_flat));

    p_test_gate_r5: assert property (@(negedge wclk) disable iff (!rst_n)
        (wr_stb && wr_id == IW'(TID) && !test_mode) |=> $stable(regs_flat));
endmodule

// File: rtl/serial_cfg_rx.sv
`timescale 1ns/1ps
module serial_cfg_rx
    import cfg_rx_pkg::*;
(
    input  logic              wclk,
    input  logic              rst_n,
    input  logic              sdi,
    input  logic              test_mode,
    output logic [4:0]        rx_gain,
    output logic [3:0]        tx_gain,
    output logic [1:0]        rx_in_sel,
    output logic              ext_gain_sel,
    output logic              osr_half,
    output logic [1:0]        loop_mode,
    output logic              vco_filt,
    output logic signed [2:0] lpf_lo_code,
    output logic signed [2:0] lpf_hi_code,
    output logic [1:0]        filt_force,
    output logic [7:0]        vdac_code,
    output logic              vdac_en,
    output logic [2:0]        gp_out,
    output logic [11:0]       pwr_down,
    output logic [11:0]       test_cfg
);
    logic                    wr_stb;
    logic [DATA_W-1:0]       wr_data;
    logic [ID_W-1:0]         wr_id;
    logic [REG_N*DATA_W-1:0] regs_flat;
    logic [DATA_W-1:0]       g_r, p_r, t_r;

    cfg_frame_rx #(.FW(FRAME_W), .IW(ID_W), .SMIN(STOP_MIN)) u_frame (
        .wclk    (wclk),
        .rst_n   (rst_n),
        .sdi     (sdi),
        .wr_stb  (wr_stb),
        .wr_data (wr_data),
        .wr_id   (wr_id)
    );

    cfg_reg_bank #(.RN(REG_N), .DW(DATA_W), .IW(ID_W), .TID(ID_TEST)) u_bank (
        .wclk      (wclk),
        .rst_n     (rst_n),
        .test_mode (test_mode),
        .wr_stb    (wr_stb),
        .wr_data   (wr_data),
        .wr_id     (wr_id),
        .regs_flat (regs_flat)
    );

    assign g_r = regs_flat[ID_GAIN*DATA_W +: DATA_W];
    assign p_r = regs_flat[ID_PATH*DATA_W +: DATA_W];
    assign t_r = regs_flat[ID_TUNE*DATA_W +: DATA_W];

    assign rx_gain      = g_r[4:0];
    assign tx_gain      = g_r[8:5];
    assign rx_in_sel    = g_r[10:9];
    assign ext_gain_sel = g_r[11];

    assign osr_half     = p_r[0];
    assign loop_mode    = p_r[2:1];
    assign vco_filt     = p_r[3];
    assign lpf_lo_code  = p_r[6:4];
    assign lpf_hi_code  = p_r[9:7];
    assign filt_force   = p_r[11:10];

    assign vdac_code    = t_r[7:0];
    assign vdac_en      = t_r[8];
    assign gp_out       = t_r[11:9];

    assign pwr_down     = regs_flat[ID_PWR*DATA_W +: DATA_W];
    assign test_cfg     = regs_flat[ID_TEST*DATA_W +: DATA_W];
endmodule

// File: tb/serial_cfg_rx_test.sv
`timescale 1ns/1ps
module serial_cfg_rx_test;
    logic wclk = 1'b0;
    logic rst_n, sdi, test_mode;
    logic [4:0] rx_gain; logic [3:0] tx_gain; logic [1:0] rx_in_sel; logic ext_gain_sel;
    logic osr_half; logic [1:0] loop_mode; logic vco_filt;
    logic signed [2:0] lpf_lo_code, lpf_hi_code; logic [1:0] filt_force;
    logic [7:0] vdac_code; logic vdac_en; logic [2:0] gp_out;
    logic [11:0] pwr_down, test_cfg;

    int n_chk = 0, n_bad = 0;
    bit done = 0;
    logic [11:0] exp_r [5];

    always #10 wclk = ~wclk;   // 50 MHz

    serial_cfg_rx uut (
        .wclk(wclk), .rst_n(rst_n), .sdi(sdi), .test_mode(test_mode),
        .rx_gain(rx_gain), .tx_gain(tx_gain), .rx_in_sel(rx_in_sel), .ext_gain_sel(ext_gain_sel),
        .osr_half(osr_half), .loop_mode(loop_mode), .vco_filt(vco_filt),
        .lpf_lo_code(lpf_lo_code), .lpf_hi_code(lpf_hi_code), .filt_force(filt_force),
        .vdac_code(vdac_code), .vdac_en(vdac_en), .gp_out(gp_out),
        .pwr_down(pwr_down), .test_cfg(test_cfg)
    );

    task automatic chk(input string tag, input string what, input logic [11:0] act, input logic [11:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
        end
    endtask

    // R10 field layout
    task automatic check_all(input string tag);
        chk(tag, "gain", {ext_gain_sel, rx_in_sel, tx_gain, rx_gain}, exp_r[0]);
        chk(tag, "path", {filt_force, lpf_hi_code, lpf_lo_code, vco_filt, loop_mode, osr_half}, exp_r[1]);
        chk(tag, "tune", {gp_out, vdac_en, vdac_code}, exp_r[2]);
        chk(tag, "pwr",  pwr_down, exp_r[3]);
        chk(tag, "test", test_cfg, exp_r[4]);
    endtask

    function automatic void set_defaults();   // R9
        exp_r[0] = 12'h600;
        for (int i = 1; i < 5; i++) exp_r[i] = 12'h000;
    endfunction

    task automatic send_bit(input logic b, input bit glitch);
        @(posedge wclk);
        sdi = b;
        if (glitch) begin
            #12 sdi = ~b;   // wrong value around the rising edge only
        end
    endtask

    // R2 frame: start 0, data, id; then nstop highs
    task automatic send_frame(input logic [2:0] id, input logic [11:0] data, input int nstop, input bit glitch);
        logic [15:0] w;
        w = {1'b0, data, id};
        for (int i = 15; i >= 0; i--) send_bit(w[i], glitch);
        for (int i = 0; i < nstop; i++) send_bit(1'b1, 1'b0);
        if (nstop >= 16 && id < 3'd5 && (id != 3'd4 || test_mode)) exp_r[id] = data;
        @(negedge wclk); #2;
    endtask

    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL R4 watchdog expired: actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'h1A2B);
        rst_n = 1'b0; sdi = 1'b1; test_mode = 1'b0;
        set_defaults();
        repeat (3) @(posedge wclk);
        #5 check_all("R9");
        @(posedge wclk); rst_n = 1'b1;
        repeat (4) @(posedge wclk);
        #5 check_all("R11");

        // R2/R3 basic word into gain register
        send_frame(3'd0, 12'hA5C, 16, 0);
        check_all("R3");
        // R1: bit levels wrong around rising edge
        send_frame(3'd3, 12'h3C9, 16, 1);
        check_all("R1");
        // R4: 15 highs not enough, 16th commits
        send_frame(3'd3, 12'h5A1, 15, 0);
        check_all("R4");
        send_bit(1'b1, 0); exp_r[3] = 12'h5A1;
        @(negedge wclk); #2;
        check_all("R4");
        // R6: long idle high, then a new word
        for (int i = 0; i < 40; i++) send_bit(1'b1, 0);
        @(negedge wclk); #2;
        check_all("R6");
        send_frame(3'd1, 12'h2B4, 18, 0);
        check_all("R6");
        // R7: interrupted stop run
        send_frame(3'd2, 12'hFFF, 10, 0);
        check_all("R7");
        send_frame(3'd2, 12'h1E7, 16, 0);
        check_all("R7");
        // R5 test gating
        test_mode = 1'b0;
        send_frame(3'd4, 12'hBEE, 16, 0);
        check_all("R5");
        test_mode = 1'b1;
        send_frame(3'd4, 12'h7D3, 16, 0);
        check_all("R5");
        test_mode = 1'b0;
        // R8 reserved identifiers
        for (int k = 5; k < 8; k++) begin
            send_frame(3'(k), 12'hC3C, 16, 0);
            check_all("R8");
        end
        // R10 signed filter codes -4 and +3
        send_frame(3'd1, {2'b00, 3'b011, 3'b100, 4'b0000}, 16, 0);
        n_chk++;
        if (lpf_lo_code != -3'sd4 || lpf_hi_code != 3'sd3) begin
            n_bad++;
            $display("FAIL R10 codes actual=%0d,%0d expected=-4,3", lpf_lo_code, lpf_hi_code);
        end
        // random words
        for (int n = 0; n < 300; n++) begin
            logic [2:0] rid; logic [11:0] rdata; int rstop;
            rid = 3'($urandom_range(0, 7));
            rdata = 12'($urandom);
            rstop = $urandom_range(10, 21);
            test_mode = 1'($urandom_range(0, 1));
            send_frame(rid, rdata, rstop, 0);
            check_all(rstop >= 16 ? "R3" : "R7");
        end
        // mid-run reset
        @(posedge wclk); rst_n = 1'b0; sdi = 1'b1;
        set_defaults();
        @(posedge wclk); #5 check_all("R9");
        rst_n = 1'b1;
        repeat (4) @(posedge wclk);
        #5 check_all("R11");
        send_frame(3'd2, 12'h9A5, 16, 0);
        check_all("R3");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule